// File: doc/BRIEF.md
# USB Endpoint Mode Response Decoder

This block decides how one low-speed USB device endpoint answers each token that arrives at it. A 4-bit mode code sits in the low nibble of an 8-bit endpoint mode register. When a decoded token arrives, that code picks the reply: acknowledge, negative acknowledge, stall, or silence. For SETUP and OUT transactions the same code also decides whether the data packet is written to the endpoint buffer and whether that data is marked valid.

The upper three bits of the register are sticky flags, one per token kind. Each flag shows that a token of that kind was taken by the endpoint, and it stays set until the CPU clears it. After any SETUP that is taken with good CRC, the block forces the mode to the negative-acknowledge mode on its own. Firmware can then handle the request before more data moves. The packet receiver and transmitter, CRC logic and the CPU are outside this block.

Each token is a one-cycle strobe carrying its type, its byte count (payload plus the two CRC bytes) and a CRC-good flag. The decision is registered and appears on the outputs in the cycle after the strobe, for one cycle only. The mode register changes on that same clock edge.

Top module: `usb_ep_responder`

## Requirements
- R1: After synchronous reset, `ep_mode_reg` reads 0x00, `hs_code` is 0 (no response), and `buf_wr` and `data_valid` are 0.
- R2: The response to a token with `tok_valid` high in cycle N appears on `hs_code`, `buf_wr` and `data_valid` in cycle N+1 only. These outputs are 0 in any cycle that does not follow a token. Handshake codes are: 0 none, 1 ACK, 2 NAK, 3 STALL.
- R3: Token types are 0 SETUP, 1 IN, 2 OUT and 3 reserved. In mode 0, in any mode from 6 to 15, and for the reserved token type in every mode, a token gives no handshake, no buffer write and no sticky flag change, and it leaves the mode unchanged.
- R4: In modes 1 to 4 a SETUP is taken. With good CRC it answers ACK, writes the buffer and sets the mode to 1. With bad CRC it answers nothing, does not write, and leaves the mode unchanged.
- R5: A SETUP taken with good CRC asserts `data_valid` only when its byte count is 10 or less. With a count of 11 or more the buffer is still written but `data_valid` stays 0.
- R6: In mode 1, IN is answered NAK, and OUT with good CRC is answered NAK.
- R7: In mode 2, OUT with good CRC and a byte count of exactly 2 (zero-length status) is answered ACK. OUT with good CRC and any other count is answered STALL, and IN is answered STALL. No buffer write occurs in any of these cases.
- R8: In mode 3, IN is answered STALL, and OUT with good CRC is answered STALL.
- R9: In mode 4, IN and OUT give no handshake, no write and no sticky flag change.
- R10: In mode 5 (isochronous OUT), SETUP and IN are ignored. OUT writes the buffer, sets `data_valid` equal to the CRC flag and never gives a handshake.
- R11: The sticky flags are bit 7 for SETUP, bit 6 for IN and bit 5 for OUT. A flag is set by a token of its kind that the current mode does not ignore, with good or bad CRC. OUT tokens with bad CRC in modes 1 to 3 set the OUT flag but give no handshake.
- R12: A CPU write loads bits [3:0] into the mode. It clears each sticky flag whose written bit is 0 and keeps each flag whose written bit is 1. Bit 4 always reads 0. A hardware flag set in the same cycle wins over a clear, and the forced change to mode 1 wins over a written mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | One-cycle strobe: a token for this endpoint |
| tok_type | input | 2 | 0 SETUP, 1 IN, 2 OUT, 3 reserved |
| byte_cnt | input | CNT_W | Data packet byte count, payload plus two CRC bytes |
| crc_ok | input | 1 | Data packet CRC good |
| cpu_wr | input | 1 | CPU write strobe to the mode register |
| cpu_wdata | input | 8 | CPU write data |
| hs_code | output | 2 | Handshake selection: 0 none, 1 ACK, 2 NAK, 3 STALL |
| buf_wr | output | 1 | Write the received packet into the endpoint buffer |
| data_valid | output | 1 | Buffer data marked valid |
| ep_mode_reg | output | 8 | Sticky flags [7:5], 0 in bit 4, mode [3:0] |

## Verification
The assertions assume that `tok_valid` is a one-cycle strobe with `tok_type`, `byte_cnt` and `crc_ok` meaningful only while it is high. They also assume that a CPU write may land in the same cycle as a token, and that both are resolved on one edge. The random stimulus drives tokens of every type, including the reserved type. It draws counts across the full width of `byte_cnt`, skewed toward the 2, 10 and 11 boundaries, and lowers the CRC flag about a quarter of the time. CPU writes mostly target the six defined modes, with some undefined codes mixed in, and they overlap tokens often enough to exercise the same-cycle priority rules.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_IN    = 2'd1,
        TK_OUT   = 2'd2,
        TK_RSVD  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    localparam logic [3:0] MD_OFF        = 4'd0;
    localparam logic [3:0] MD_NAK        = 4'd1;
    localparam logic [3:0] MD_STATUS_OUT = 4'd2;
    localparam logic [3:0] MD_STALL      = 4'd3;
    localparam logic [3:0] MD_QUIET      = 4'd4;
    localparam logic [3:0] MD_ISO_OUT    = 4'd5;

    localparam int FLAG_W     = 3;
    localparam int FLAG_SETUP = 2;
    localparam int FLAG_IN    = 1;
    localparam int FLAG_OUT   = 0;

    typedef struct packed {
        hs_e               hs;
        logic              wr;
        logic              dv;
        logic [FLAG_W-1:0] set;
        logic              force_nak;
    } resp_t;

    function automatic logic takes_setup(input logic [3:0] m);
        return (m >= MD_NAK) && (m <= MD_QUIET);
    endfunction

    function automatic logic answers_in_out(input logic [3:0] m);
        return (m == MD_NAK) || (m == MD_STATUS_OUT) || (m == MD_STALL);
    endfunction

endpackage

// File: rtl/usb_ep_decode.sv
module usb_ep_decode
    import usb_ep_pkg::*;
#(
    parameter int CNT_W      = 5,
    parameter int SETUP_MAX  = 10,
    parameter int STATUS_CNT = 2
) (
    input  logic [3:0]       mode,
    input  logic [1:0]       tok,
    input  logic [CNT_W-1:0] cnt,
    input  logic             crc_ok,
    output resp_t            resp
);

    localparam logic [CNT_W-1:0] SETUP_LIM = CNT_W'(SETUP_MAX);
    localparam logic [CNT_W-1:0] STAT_LEN  = CNT_W'(STATUS_CNT);

    always_comb begin
        resp = '0;
        resp.hs = HS_NONE;
        unique case (tok_e'(tok))
            TK_SETUP: begin
                if (takes_setup(mode)) begin
                    resp.set[FLAG_SETUP] = 1'b1;
                    if (crc_ok) begin
                        resp.hs        = HS_ACK;
                        resp.wr        = 1'b1;
                        resp.dv        = (cnt <= SETUP_LIM);
                        resp.force_nak = 1'b1;
                    end
                end
            end
            TK_IN: begin
                if (answers_in_out(mode)) begin
                    resp.set[FLAG_IN] = 1'b1;
                    resp.hs = (mode == MD_NAK) ? HS_NAK : HS_STALL;
                end
            end
            TK_OUT: begin
                if (mode == MD_ISO_OUT) begin
                    resp.set[FLAG_OUT] = 1'b1;
                    resp.wr = 1'b1;
                    resp.dv = crc_ok;
                end else if (answers_in_out(mode)) begin
                    resp.set[FLAG_OUT] = 1'b1;
                    if (crc_ok) begin
                        if (mode == MD_NAK)
                            resp.hs = HS_NAK;
                        else if (mode == MD_STATUS_OUT && cnt == STAT_LEN)
                            resp.hs = HS_ACK;
                        else
                            resp.hs = HS_STALL;
                    end
                end
            end
            default: resp = '0;
        endcase
    end

endmodule

// File: rtl/usb_ep_modereg.sv
module usb_ep_modereg
    import usb_ep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    input  logic [FLAG_W-1:0] hw_set,
    input  logic              force_nak,
    output logic [3:0]        mode,
    output logic [FLAG_W-1:0] flags
);

    logic [FLAG_W-1:0] clr_mask;
    logic              unused_bit4;

    assign unused_bit4 = cpu_wdata[4];
    assign clr_mask    = cpu_wr ? ~cpu_wdata[7:5] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= MD_OFF;
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_mask) | hw_set;
            if (force_nak)
                mode <= MD_NAK;
            else if (cpu_wr)
                mode <= cpu_wdata[3:0];
        end
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((($past(flags) & ~($past(cpu_wr) ? ~$past(cpu_wdata[7:5]) : 3'b000)) & ~flags) == 3'b000)); // R12

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((flags & $past(hw_set)) == $past(hw_set))); // R11

    AST_FORCE_NAK: assert property (@(posedge clk) disable iff (rst)
        force_nak |=> (mode == MD_NAK)); // R4

endmodule

// File: rtl/usb_ep_responder.sv
module usb_ep_responder
    import usb_ep_pkg::*;
#(
    parameter int CNT_W      = 5,
    parameter int SETUP_MAX  = 10,
    parameter int STATUS_CNT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_valid,
    input  logic [1:0]       tok_type,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             crc_ok,
    input  logic             cpu_wr,
    input  logic [7:0]       cpu_wdata,
    output logic [1:0]       hs_code,
    output logic             buf_wr,
    output logic             data_valid,
    output logic [7:0]       ep_mode_reg
);

    logic [3:0]        mode_q;
    logic [FLAG_W-1:0] flags_q;
    resp_t             dec;
    logic [FLAG_W-1:0] hw_set;
    logic              force_nak;
    hs_e               hs_q;

    usb_ep_decode #(
        .CNT_W      (CNT_W),
        .SETUP_MAX  (SETUP_MAX),
        .STATUS_CNT (STATUS_CNT)
    ) u_decode (
        .mode   (mode_q),
        .tok    (tok_type),
        .cnt    (byte_cnt),
        .crc_ok (crc_ok),
        .resp   (dec)
    );

    assign hw_set    = tok_valid ? dec.set : '0;
    assign force_nak = tok_valid & dec.force_nak;

    usb_ep_modereg u_modereg (
        .clk       (clk),
        .rst       (rst),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .hw_set    (hw_set),
        .force_nak (force_nak),
        .mode      (mode_q),
        .flags     (flags_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q       <= HS_NONE;
            buf_wr     <= 1'b0;
            data_valid <= 1'b0;
        end else begin
            hs_q       <= tok_valid ? dec.hs : HS_NONE;
            buf_wr     <= tok_valid & dec.wr;
            data_valid <= tok_valid & dec.dv;
        end
    end

    assign hs_code     = hs_q;
    assign ep_mode_reg = {flags_q, 1'b0, mode_q};

    AST_DV_NEEDS_WR: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> buf_wr); // R5

    AST_WR_NO_REJECT: assert property (@(posedge clk) disable iff (rst)
        buf_wr |-> (hs_code == HS_NONE || hs_code == HS_ACK)); // R10

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && mode_q == MD_OFF) |=> (hs_code == HS_NONE && !buf_wr)); // R3

    AST_STALL_MODE: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && mode_q == MD_STALL && tok_type == TK_IN) |=> (hs_code == HS_STALL)); // R8

    AST_ISO_NO_HS: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && mode_q == MD_ISO_OUT) |=> (hs_code == HS_NONE)); // R10

    AST_NO_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
        !tok_valid |=> (hs_code == HS_NONE && !buf_wr && !data_valid)); // R2

endmodule

// File: tb/usb_ep_responder_tb.sv
module usb_ep_responder_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       tok_valid;
    logic [1:0] tok_type;
    logic [4:0] byte_cnt;
    logic       crc_ok;
    logic       cpu_wr;
    logic [7:0] cpu_wdata;
    logic [1:0] hs_code;
    logic       buf_wr;
    logic       data_valid;
    logic [7:0] ep_mode_reg;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [3:0] m_mode;
    logic [2:0] m_flags;
    logic [1:0] e_hs;
    logic       e_wr;
    logic       e_dv;

    always #2 clk = ~clk;

    usb_ep_responder u_dut (
        .clk         (clk),
        .rst         (rst),
        .tok_valid   (tok_valid),
        .tok_type    (tok_type),
        .byte_cnt    (byte_cnt),
        .crc_ok      (crc_ok),
        .cpu_wr      (cpu_wr),
        .cpu_wdata   (cpu_wdata),
        .hs_code     (hs_code),
        .buf_wr      (buf_wr),
        .data_valid  (data_valid),
        .ep_mode_reg (ep_mode_reg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Returns {hs[1:0], wr, dv, flag_set{setup,in,out}, force}
    function automatic logic [7:0] model(input logic [3:0] md, input logic [1:0] tk,
                                         input logic [4:0] c, input bit ok);
        logic [1:0] h = 2'd0;
        bit w = 0, d = 0, f = 0;
        logic [2:0] s = 3'b000;
        bit resp_mode = (md == 4'd1) || (md == 4'd2) || (md == 4'd3);
        if (tk == 2'd0 && md >= 4'd1 && md <= 4'd4) begin
            s = 3'b100;
            if (ok) begin
                h = 2'd1; w = 1; d = (c <= 5'd10); f = 1;
            end
        end else if (tk == 2'd1 && resp_mode) begin
            s = 3'b010;
            h = (md == 4'd1) ? 2'd2 : 2'd3;
        end else if (tk == 2'd2) begin
            if (md == 4'd5) begin
                s = 3'b001; w = 1; d = ok;
            end else if (resp_mode) begin
                s = 3'b001;
                if (ok) h = (md == 4'd1) ? 2'd2 : ((md == 4'd2 && c == 5'd2) ? 2'd1 : 2'd3);
            end
        end
        return {h, w, d, s, f};
    endfunction

    task automatic step(input string tag, input bit tv, input logic [1:0] tt,
                        input logic [4:0] c, input bit ok, input bit w, input logic [7:0] wd);
        logic [7:0] r;
        tok_valid = tv; tok_type = tt; byte_cnt = c; crc_ok = ok;
        cpu_wr = w; cpu_wdata = wd;
        r = tv ? model(m_mode, tt, c, ok) : 8'h00;
        @(posedge clk);
        e_hs = r[7:6]; e_wr = r[5]; e_dv = r[4];
        m_flags = (m_flags & (w ? wd[7:5] : 3'b111)) | r[3:1];
        if (r[0]) m_mode = 4'd1;
        else if (w) m_mode = wd[3:0];
        @(negedge clk);
        tok_valid = 0; cpu_wr = 0;
        chk(tag, 32'(hs_code), 32'(e_hs));
        chk(tag, 32'(buf_wr), 32'(e_wr));
        chk(tag, 32'(data_valid), 32'(e_dv));
        chk(tag, 32'(ep_mode_reg), 32'({m_flags, 1'b0, m_mode}));
    endtask

    task automatic wr_reg(input string tag, input logic [7:0] d);
        step(tag, 0, 2'd0, 5'd0, 1, 1, d);
    endtask

    task automatic tok(input string tag, input logic [1:0] tt, input logic [4:0] c, input bit ok);
        step(tag, 1, tt, c, ok, 0, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd5813));
        rst = 1; tok_valid = 0; tok_type = 0; byte_cnt = 0; crc_ok = 0;
        cpu_wr = 0; cpu_wdata = 0;
        m_mode = 0; m_flags = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", 32'(ep_mode_reg), 32'h00);
        chk("R1", 32'(hs_code), 32'h0);
        chk("R1", 32'(buf_wr), 32'h0);
        chk("R1", 32'(data_valid), 32'h0);

        // R3 disabled, undefined mode, reserved token
        tok("R3", 2'd0, 5'd10, 1);
        tok("R3", 2'd1, 5'd0, 1);
        tok("R3", 2'd2, 5'd4, 1);
        wr_reg("R3", 8'h09);
        tok("R3", 2'd0, 5'd10, 1);
        tok("R3", 2'd2, 5'd2, 1);
        chk("R3", 32'(ep_mode_reg), 32'h09);
        wr_reg("R3", 8'h01);
        tok("R3", 2'd3, 5'd2, 1);
        chk("R3", 32'(hs_code), 32'h0);

        // R4 SETUP accept, forced NAK mode; bad CRC
        wr_reg("R4", 8'h02);
        tok("R4", 2'd0, 5'd10, 1);
        chk("R4", 32'(hs_code), 32'h1);
        chk("R4", 32'(ep_mode_reg), 32'h81);
        wr_reg("R4", 8'h03);
        tok("R4", 2'd0, 5'd10, 0);
        chk("R4", 32'(hs_code), 32'h0);
        chk("R4", 32'(ep_mode_reg), 32'h83);

        // R5 byte count limit
        wr_reg("R5", 8'h04);
        tok("R5", 2'd0, 5'd11, 1);
        chk("R5", 32'({buf_wr, data_valid}), 32'h2);
        wr_reg("R5", 8'h04);
        tok("R5", 2'd0, 5'd3, 1);
        chk("R5", 32'({buf_wr, data_valid}), 32'h3);

        // R6 NAK mode, then R2 single-cycle output
        wr_reg("R6", 8'h01);
        tok("R6", 2'd1, 5'd0, 1);
        chk("R6", 32'(hs_code), 32'h2);
        step("R2", 0, 2'd0, 5'd0, 0, 0, 8'h00);
        chk("R2", 32'(hs_code), 32'h0);
        tok("R6", 2'd2, 5'd6, 1);
        chk("R6", 32'(hs_code), 32'h2);

        // R7 status OUT mode
        wr_reg("R7", 8'h02);
        tok("R7", 2'd2, 5'd2, 1);
        chk("R7", 32'(hs_code), 32'h1);
        tok("R7", 2'd2, 5'd5, 1);
        chk("R7", 32'(hs_code), 32'h3);
        tok("R7", 2'd1, 5'd0, 1);
        chk("R7", 32'(hs_code), 32'h3);

        // R8 stall mode
        wr_reg("R8", 8'h03);
        tok("R8", 2'd1, 5'd0, 1);
        tok("R8", 2'd2, 5'd4, 1);
        chk("R8", 32'(hs_code), 32'h3);

        // R9 quiet mode
        wr_reg("R9", 8'h04);
        tok("R9", 2'd1, 5'd0, 1);
        tok("R9", 2'd2, 5'd4, 1);
        chk("R9", 32'(ep_mode_reg), 32'h04);

        // R10 isochronous OUT
        wr_reg("R10", 8'h05);
        tok("R10", 2'd0, 5'd10, 1);
        tok("R10", 2'd1, 5'd0, 1);
        chk("R10", 32'(ep_mode_reg), 32'h05);
        tok("R10", 2'd2, 5'd9, 1);
        chk("R10", 32'({hs_code, buf_wr, data_valid}), 32'h3);
        tok("R10", 2'd2, 5'd9, 0);
        chk("R10", 32'({hs_code, buf_wr, data_valid}), 32'h2);

        // R11 flag positions; bad-CRC OUT sets flag silently
        chk("R11", 32'(ep_mode_reg), 32'h25);
        wr_reg("R11", 8'h01);
        tok("R11", 2'd2, 5'd4, 0);
        chk("R11", 32'({ep_mode_reg, hs_code}), 32'({8'h21, 2'd0}));
        tok("R11", 2'd1, 5'd0, 1);
        chk("R11", 32'(ep_mode_reg), 32'h61);

        // R12 write semantics and priorities
        wr_reg("R12", 8'hF5);
        chk("R12", 32'(ep_mode_reg), 32'h65);
        step("R12", 1, 2'd2, 5'd3, 1, 1, 8'h06);
        chk("R12", 32'(ep_mode_reg), 32'h26);
        wr_reg("R12", 8'h02);
        step("R12", 1, 2'd0, 5'd10, 1, 1, 8'h03);
        chk("R12", 32'(ep_mode_reg), 32'h81);
        wr_reg("R12", 8'h1F);
        chk("R12", 32'(ep_mode_reg), 32'h0F);

        // Random mix against the bench model
        for (int i = 0; i < 800; i++) begin
            logic [4:0] c;
            logic [7:0] wd;
            bit tv = ($urandom % 3) != 0;
            bit w  = ($urandom % 4) == 0;
            logic [1:0] tt = 2'($urandom % 4);
            bit ok = ($urandom % 4) != 0;
            case ($urandom % 4)
                0: c = 5'd2;
                1: c = 5'($urandom % 2 + 10);
                default: c = 5'($urandom % 32);
            endcase
            wd = 8'($urandom);
            if (($urandom % 5) != 0) wd[3:0] = 4'($urandom % 6);
            step("R2", tv, tt, c, ok, w, wd);
        end

        finish_run();
    end

endmodule